// File: doc/BRIEF.md
# Exception Priority Resolver

This block picks the single exception to accept from all the flags that one issue unit has pending. An issue unit is one of three things: a plain instruction, an instruction that makes two data accesses, or a delayed branch fused with its delay slot instruction. The fused pair counts as one indivisible unit. Flags arrive in two groups:
- per data access: address error, TLB miss, protection violation and first write to a clean page;
- per instruction: pending exceptions sorted by priority level and by kind (interrupt or re-execution, completion).

The resolver ranks the pending causes and registers the winner, together with its source: branch or slot instruction, and first or second access. It also produces the control for the branch's return-address register write.

In a fused pair the checks run in stages rather than from one flat list:
1. the branch's level-1/2 interrupt and re-execution causes;
2. the same group in the slot instruction;
3. completion-type level-2 causes, branch before slot;
4. level 3 across both instructions;
5. level 4 across both instructions.

The winner is registered on the clock edge that samples the inputs. The result is therefore visible for one cycle after each sampled issue unit.

Top module: `ep_prio_resolver`

## Requirements
- R1: Outputs are registered. The result for inputs sampled with `in_vld` high appears after the next rising edge. When `in_vld` was low at that edge, the outputs take the idle values: `out_vld`=0, `out_code`=0, `out_slot`=0, `out_acc`=0, `out_pr_wr_ok`=1, `out_pr_undef`=0.
- R2: `out_vld` is high exactly when at least one flag that counts under R4/R5 is set. Otherwise `out_code` is 0.
- R3: Within one access, priority runs from highest to lowest as address error, TLB miss, protection violation, first write. These are flag bits 0, 1, 2, 3 of an access vector and codes 3, 4, 5, 6.
- R4: For an instruction with `*_two_acc` high, every second-access flag ranks below every first-access flag. When `*_two_acc` is low, the second-access flags are ignored.
- R5: For a plain instruction (`in_fused`=0) the order from highest to lowest is:
  - code 1: pend bit 0, level-1 interrupt/re-execution;
  - code 2: pend bit 1, level-2 re-execution;
  - the access causes (codes 3 to 6);
  - code 7: pend bit 2, level-2 completion;
  - code 8: pend bit 3, level 3;
  - code 9: pend bit 4, level 4.
  All slot inputs are ignored in this mode.
- R6: In fused mode, every branch cause with code 1 to 6 ranks above every slot cause with code 1 to 6. Every slot cause with code 1 to 6 ranks above any cause with code 7 to 9.
- R7: In fused mode, branch completion (code 7) ranks above slot completion. Both rank above any level-3 or level-4 cause.
- R8: In fused mode, level 3 in either instruction ranks above level 4 in either instruction. At the same level, the branch wins over the slot.
- R9: `out_pr_wr_ok` is 0 when the winner has code 1, or when the winner comes from the branch with code 2 to 6. Otherwise it is 1. `out_pr_undef` is 1 exactly when the winner comes from the slot with code 2 to 6.
- R10: `out_slot` is 0 for the branch or plain instruction and 1 for the slot instruction. `out_acc` is 1 only when the winner is a code 3 to 6 from the second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Issue unit flags are valid this cycle |
| in_fused | input | 1 | 1: branch plus delay slot pair; 0: plain instruction |
| br_two_acc | input | 1 | Branch/plain instruction makes two data accesses |
| br_pend | input | 5 | Branch/plain instruction flags: [0] L1 int/re-exec, [1] L2 re-exec, [2] L2 completion, [3] L3, [4] L4 |
| br_acc | input | 8 | Branch/plain access flags: [3:0] first access, [7:4] second access |
| sl_two_acc | input | 1 | Slot instruction makes two data accesses |
| sl_pend | input | 5 | Slot instruction flags, same layout as br_pend |
| sl_acc | input | 8 | Slot access flags, same layout as br_acc |
| out_vld | output | 1 | An exception was accepted |
| out_code | output | 4 | Winning cause code (0 none, 1..9) |
| out_slot | output | 1 | Winner came from the slot instruction |
| out_acc | output | 1 | Winner came from the second data access |
| out_pr_wr_ok | output | 1 | Branch return-address register write may proceed |
| out_pr_undef | output | 1 | Return-address register value is undefined |

## Verification
The hardest situations to reach from the ports are those where ordering matters across stages. Two examples:
- a slot access fault coexisting with a branch completion or level-3 flag;
- a first-access low-rank cause coexisting with a second-access high-rank cause.

These only show up when two specific flags are raised together. The stimulus therefore sweeps every pair of the 28 flag and mode bits, in both plain and fused mode, with both two-access settings forced. A sparse random phase follows, in which many flags are pending at once. Idle cycles with flags still driven are inserted periodically to show that unsampled inputs leave no trace.

// File: rtl/ep_pkg.sv
package ep_pkg;

    localparam int ACC_N  = 2;
    localparam int ACC_FL = 4;
    localparam int LVL_N  = 5;
    localparam int CODE_W = 4;
    localparam int ACC_W  = ACC_N * ACC_FL;

    localparam int P_L1   = 0;
    localparam int P_L2RE = 1;
    localparam int P_CMP  = 2;
    localparam int P_L3   = 3;
    localparam int P_L4   = 4;

    typedef enum logic [CODE_W-1:0] {
        C_NONE  = 4'd0,
        C_L1    = 4'd1,
        C_L2RE  = 4'd2,
        C_ADE   = 4'd3,
        C_TLBM  = 4'd4,
        C_PROT  = 4'd5,
        C_FWR   = 4'd6,
        C_L2CMP = 4'd7,
        C_L3    = 4'd8,
        C_L4    = 4'd9
    } cause_e;

    typedef struct packed {
        logic   hit;
        cause_e code;
        logic   acc;
        logic   slot;
    } win_t;

    localparam win_t WIN_NONE = '{hit: 1'b0, code: C_NONE, acc: 1'b0, slot: 1'b0};

    function automatic cause_e acc_cause(input logic [ACC_FL-1:0] f);
        cause_e c;
        c = C_NONE;
        for (int k = ACC_FL - 1; k >= 0; k--) begin
            if (f[k]) c = cause_e'(CODE_W'(int'(C_ADE) + k));
        end
        return c;
    endfunction

    function automatic logic is_reexec(input cause_e c);
        return (c >= C_L2RE) && (c <= C_FWR);
    endfunction

endpackage

// File: rtl/ep_instr_scan.sv
module ep_instr_scan
    import ep_pkg::*;
(
    input  logic [LVL_N-1:0] pend,
    input  logic             two_acc,
    input  logic [ACC_W-1:0] acc_fl,
    output win_t             grp_a,
    output logic             cmp_hit,
    output logic             l3_hit,
    output logic             l4_hit
);

    logic [ACC_N-1:0] a_hit;
    cause_e           a_code [ACC_N];

    for (genvar a = 0; a < ACC_N; a++) begin : g_acc
        logic enable;
        if (a == 0) begin : g_first
            assign enable = 1'b1;
        end else begin : g_later
            assign enable = two_acc;
        end
        assign a_hit[a]  = enable && (|acc_fl[a*ACC_FL +: ACC_FL]);
        assign a_code[a] = acc_cause(acc_fl[a*ACC_FL +: ACC_FL]);
    end

    always_comb begin
        grp_a = WIN_NONE;
        if (pend[P_L1]) begin
            grp_a.hit  = 1'b1;
            grp_a.code = C_L1;
        end else if (pend[P_L2RE]) begin
            grp_a.hit  = 1'b1;
            grp_a.code = C_L2RE;
        end else begin
            for (int a = ACC_N - 1; a >= 0; a--) begin
                if (a_hit[a]) begin
                    grp_a.hit  = 1'b1;
                    grp_a.code = a_code[a];
                    grp_a.acc  = (a != 0);
                end
            end
        end
    end

    assign cmp_hit = pend[P_CMP];
    assign l3_hit  = pend[P_L3];
    assign l4_hit  = pend[P_L4];

endmodule

// File: rtl/ep_merge.sv
module ep_merge
    import ep_pkg::*;
(
    input  logic fused,
    input  win_t br_a,
    input  win_t sl_a,
    input  logic br_cmp,
    input  logic sl_cmp,
    input  logic br_l3,
    input  logic sl_l3,
    input  logic br_l4,
    input  logic sl_l4,
    output win_t win
);

    logic s_cmp, s_l3, s_l4;

    assign s_cmp = fused && sl_cmp;
    assign s_l3  = fused && sl_l3;
    assign s_l4  = fused && sl_l4;

    always_comb begin
        win = WIN_NONE;
        if (br_a.hit) begin
            win      = br_a;
            win.slot = 1'b0;
        end else if (fused && sl_a.hit) begin
            win      = sl_a;
            win.slot = 1'b1;
        end else if (br_cmp || s_cmp) begin
            win.hit  = 1'b1;
            win.code = C_L2CMP;
            win.slot = !br_cmp;
        end else if (br_l3 || s_l3) begin
            win.hit  = 1'b1;
            win.code = C_L3;
            win.slot = !br_l3;
        end else if (br_l4 || s_l4) begin
            win.hit  = 1'b1;
            win.code = C_L4;
            win.slot = !br_l4;
        end
    end

endmodule

// File: rtl/ep_prio_resolver.sv
module ep_prio_resolver
    import ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_fused,
    input  logic              br_two_acc,
    input  logic [LVL_N-1:0]  br_pend,
    input  logic [ACC_W-1:0]  br_acc,
    input  logic              sl_two_acc,
    input  logic [LVL_N-1:0]  sl_pend,
    input  logic [ACC_W-1:0]  sl_acc,
    output logic              out_vld,
    output logic [CODE_W-1:0] out_code,
    output logic              out_slot,
    output logic              out_acc,
    output logic              out_pr_wr_ok,
    output logic              out_pr_undef
);

    localparam int INSTR_N = 2;

    logic [LVL_N-1:0] pend_v [INSTR_N];
    logic [ACC_W-1:0] acc_v  [INSTR_N];
    logic             two_v  [INSTR_N];
    win_t             grp_v  [INSTR_N];
    logic             cmp_v  [INSTR_N];
    logic             l3_v   [INSTR_N];
    logic             l4_v   [INSTR_N];

    assign pend_v[0] = br_pend;
    assign pend_v[1] = sl_pend;
    assign acc_v[0]  = br_acc;
    assign acc_v[1]  = sl_acc;
    assign two_v[0]  = br_two_acc;
    assign two_v[1]  = sl_two_acc;

    for (genvar i = 0; i < INSTR_N; i++) begin : g_scan
        ep_instr_scan u_scan (
            .pend    (pend_v[i]),
            .two_acc (two_v[i]),
            .acc_fl  (acc_v[i]),
            .grp_a   (grp_v[i]),
            .cmp_hit (cmp_v[i]),
            .l3_hit  (l3_v[i]),
            .l4_hit  (l4_v[i])
        );
    end

    win_t win_c;

    ep_merge u_merge (
        .fused  (in_fused),
        .br_a   (grp_v[0]),
        .sl_a   (grp_v[1]),
        .br_cmp (cmp_v[0]),
        .sl_cmp (cmp_v[1]),
        .br_l3  (l3_v[0]),
        .sl_l3  (l3_v[1]),
        .br_l4  (l4_v[0]),
        .sl_l4  (l4_v[1]),
        .win    (win_c)
    );

    logic pr_block_c, pr_undef_c;

    always_comb begin
        pr_block_c = 1'b0;
        pr_undef_c = 1'b0;
        if (win_c.hit) begin
            pr_block_c = (win_c.code == C_L1) || (!win_c.slot && is_reexec(win_c.code));
            pr_undef_c = win_c.slot && is_reexec(win_c.code);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !in_vld) begin
            out_vld      <= 1'b0;
            out_code     <= C_NONE;
            out_slot     <= 1'b0;
            out_acc      <= 1'b0;
            out_pr_wr_ok <= 1'b1;
            out_pr_undef <= 1'b0;
        end else begin
            out_vld      <= win_c.hit;
            out_code     <= win_c.code;
            out_slot     <= win_c.slot;
            out_acc      <= win_c.acc;
            out_pr_wr_ok <= !pr_block_c;
            out_pr_undef <= pr_undef_c;
        end
    end

endmodule

// File: rtl/ep_prio_chk.sv
module ep_prio_chk
    import ep_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              in_fused,
    input logic              br_two_acc,
    input logic [LVL_N-1:0]  br_pend,
    input logic [ACC_W-1:0]  br_acc,
    input logic              sl_two_acc,
    input logic [LVL_N-1:0]  sl_pend,
    input logic [ACC_W-1:0]  sl_acc,
    input logic              out_vld,
    input logic [CODE_W-1:0] out_code,
    input logic              out_slot,
    input logic              out_acc,
    input logic              out_pr_wr_ok,
    input logic              out_pr_undef
);

    // R1: an unsampled cycle leaves idle outputs
    a_r1_idle_after_gap: assert property (@(posedge clk) disable iff (rst)
        !$past(in_vld) |-> (!out_vld && !out_slot && !out_acc && out_pr_wr_ok));

    // R2: valid and a non-zero code go together
    a_r2_vld_code: assert property (@(posedge clk) disable iff (rst)
        out_vld == (out_code != 4'd0));

    // R5: plain mode never names the slot
    a_r5_plain_no_slot: assert property (@(posedge clk) disable iff (rst)
        $past(in_vld && !in_fused) |-> !out_slot);

    // R4: a single-access plain instruction never reports the second access
    a_r4_single_acc: assert property (@(posedge clk) disable iff (rst)
        $past(in_vld && !in_fused && !br_two_acc) |-> !out_acc);

    // R9: undefined return address only with the write allowed and a slot winner
    a_r9_undef_ctl: assert property (@(posedge clk) disable iff (rst)
        out_pr_undef |-> (out_pr_wr_ok && out_slot));

    // R10: access index only for access causes
    a_r10_acc_code: assert property (@(posedge clk) disable iff (rst)
        out_acc |-> (out_code >= 4'd3 && out_code <= 4'd6));

endmodule

bind ep_prio_resolver ep_prio_chk u_chk (.*);

// File: tb/sim_ep_prio_resolver.sv
`timescale 1ns/1ps
module sim_ep_prio_resolver;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_vld, in_fused, br_two_acc, sl_two_acc;
    logic [4:0] br_pend, sl_pend;
    logic [7:0] br_acc, sl_acc;
    logic       out_vld, out_slot, out_acc, out_pr_wr_ok, out_pr_undef;
    logic [3:0] out_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    ep_prio_resolver u0 (.*);

    // flag word per instruction: [4:0] pend, [5] two_acc, [9:6] access 0, [13:10] access 1
    task automatic drive(input bit v, input bit fu, input logic [13:0] b, input logic [13:0] s);
        in_vld     = v;
        in_fused   = fu;
        br_pend    = b[4:0];
        br_two_acc = b[5];
        br_acc     = b[13:6];
        sl_pend    = s[4:0];
        sl_two_acc = s[5];
        sl_acc     = s[13:6];
    endtask

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // rank model: lower rank wins
    task automatic model(input bit fu, input logic [13:0] b, input logic [13:0] s,
                         output int code, output int slot, output int acc);
        int best;
        logic [13:0] w;
        best = 1000; code = 0; slot = 0; acc = 0;
        for (int i = 0; i < 2; i++) begin
            if (i == 1 && !fu) continue;
            w = (i == 0) ? b : s;
            for (int c = 0; c < 14; c++) begin
                int r, cd, ac;
                if (!w[c] || c == 5) continue;
                ac = 0;
                if (c == 0)       begin r = i*10;     cd = 1; end
                else if (c == 1)  begin r = i*10 + 1; cd = 2; end
                else if (c == 2)  begin r = 20 + i;   cd = 7; end
                else if (c == 3)  begin r = 22 + i;   cd = 8; end
                else if (c == 4)  begin r = 24 + i;   cd = 9; end
                else begin
                    int a, k;
                    a = (c - 6) / 4; k = (c - 6) % 4;
                    if (a == 1 && !w[5]) continue;
                    r = i*10 + 2 + a*4 + k; cd = 3 + k; ac = a;
                end
                if (r < best) begin best = r; code = cd; slot = i; acc = ac; end
            end
        end
    endtask

    task automatic run_vec(input bit fu, input logic [13:0] b, input logic [13:0] s);
        int ec, es, ea, ewr, eun;
        string tg;
        drive(1'b1, fu, b, s);
        @(negedge clk);
        model(fu, b, s, ec, es, ea);
        ewr = (ec == 1 || (es == 0 && ec >= 2 && ec <= 6)) ? 0 : 1;
        eun = (es == 1 && ec >= 2 && ec <= 6) ? 1 : 0;
        if (ec == 0)      tg = "R2";
        else if (ec >= 8) tg = "R8";
        else if (ec == 7) tg = "R7";
        else if (es == 1) tg = "R6";
        else if (ea == 1) tg = "R4";
        else if (ec >= 3) tg = "R3";
        else              tg = "R5";
        check("R2", int'(out_vld), (ec != 0) ? 1 : 0, "vld");
        check(tg, int'(out_code), ec, "code");
        check("R10", int'(out_slot), es, "slot");
        check("R10", int'(out_acc), ea, "acc");
        check("R9", int'(out_pr_wr_ok), ewr, "pr_wr_ok");
        check("R9", int'(out_pr_undef), eun, "pr_undef");
    endtask

    task automatic idle_vec(input logic [13:0] b, input logic [13:0] s);
        drive(1'b0, 1'b1, b, s);
        @(negedge clk);
        check("R1", int'(out_vld), 0, "idle vld");
        check("R1", int'(out_code), 0, "idle code");
        check("R1", int'(out_pr_wr_ok), 1, "idle pr_wr_ok");
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [27:0] v;
        rst = 1'b1;
        drive(1'b0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        // reset state (R1)
        check("R1", int'(out_vld), 0, "reset vld");
        check("R1", int'(out_pr_wr_ok), 1, "reset pr_wr_ok");
        check("R1", int'(out_pr_undef), 0, "reset pr_undef");
        rst = 1'b0;

        // R5: slot flags ignored in plain mode
        drive(1'b1, 1'b0, '0, 14'h3fff);
        @(negedge clk);
        check("R5", int'(out_vld), 0, "plain ignores slot");
        // R4: second access ignored without two_acc (address error in access 1)
        drive(1'b1, 1'b0, 14'h0400, '0);
        @(negedge clk);
        check("R4", int'(out_vld), 0, "acc1 ignored");
        // R8 tie: L3 in both, branch wins
        run_vec(1'b1, 14'h0008, 14'h0008);
        // R9: slot re-execution winner with branch completion pending
        run_vec(1'b1, 14'h0004, 14'h0040);
        // R1 idle after activity
        idle_vec(14'h3fff, 14'h3fff);

        // pair sweep over all flag bits, both modes, both two_acc settings
        for (int t = 0; t < 2; t++) begin
            for (int fu = 0; fu < 2; fu++) begin
                for (int i = 0; i < 28; i++) begin
                    for (int j = i + 1; j < 28; j++) begin
                        v = '0;
                        v[i] = 1'b1;
                        v[j] = 1'b1;
                        v[5] = t[0];
                        v[19] = t[0];
                        run_vec(fu[0], v[13:0], v[27:14]);
                    end
                end
            end
        end

        // sparse random phase
        for (int n = 0; n < 4000; n++) begin
            logic [27:0] r;
            r = 28'($urandom) & 28'($urandom) & 28'($urandom | $urandom);
            if (n % 9 == 8) idle_vec(r[13:0], r[27:14]);
            else            run_vec(n[0], r[13:0], r[27:14]);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule